// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked user port and an external asynchronous static RAM with 18 address bits and a 24-bit bidirectional data bus. The user offers one word at a time through a valid/ready handshake, with a write flag, an address and write data. The controller then drives the memory's address bus, its three chip enables, write enable and output enable, and a tristate data bus made of separate out, in and drive-enable signals. Every phase is held for a whole number of clock cycles that is derived from the memory's nanosecond minimums.

The clock period and each timing minimum are parameters given in picoseconds. Each phase length is the ceiling of the minimum divided by the clock period, and is never less than one cycle. A write holds write enable low long enough to cover the pulse width, the data setup and the address-to-end time. Write enable then returns high one cycle before the address or data may change. A read holds output enable low long enough to cover the access, cycle and output-enable delays. The word is sampled at the last edge of that window. The controller then waits for the memory to release the bus before it returns ready.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, the memory is deselected (ce1_n=1, ce2=0, ce3_n=1), mem_we_no=1, mem_oe_no=1, mem_dq_oe_o=0, req_ready_o=1 and rd_valid_o=0.
- R2: The chip is selected (ce1_n=0, ce2=1, ce3_n=0) in every cycle of an access and deselected (1,0,1) whenever the controller is idle. Write enable or output enable is low only while the chip is selected.
- R3: An accepted write drives mem_we_no low for N_PWE = max(ceil(pulse), ceil(data setup), ceil(address-to-end)) consecutive cycles, starting in the cycle after acceptance. During those cycles mem_oe_no is high and mem_dq_o carries the request data. With the defaults this is 2 cycles.
- R4: mem_addr_o holds the request address from the cycle after acceptance until the controller is ready again. Address and write data are still unchanged in the cycle after write enable rises.
- R5: An accepted read drives mem_oe_no low, with mem_we_no high and mem_dq_oe_o low, for N_RD = max(ceil(read cycle), ceil(address access), ceil(output-enable access)) cycles (3 by default). mem_dq_i is sampled at the last edge of that window. rd_valid_o then pulses for exactly one cycle, with rd_data_o holding that word.
- R6: mem_dq_oe_o is high only while mem_oe_no is high and mem_we_no is low, and never in the cycle after mem_oe_no was low. After a read, the bus is left undriven with output enable high for N_TA = ceil(output-enable release) cycles (2 by default) before ready returns.
- R7: req_ready_o is low from the cycle after acceptance until the access, including recovery, is complete. A request held valid during that time is not acted on.
- R8: rd_data_o changes only on a read capture. Writes and bus activity at other times leave it unchanged.
- R9: A write keeps the controller busy for N_PWE + max(1, ceil(write cycle) − N_PWE) cycles (3 by default), and a read for N_RD + N_TA cycles (5 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 24 | Write data |
| rd_valid_o | output | 1 | One-cycle read-data strobe |
| rd_data_o | output | 24 | Last word read |
| mem_addr_o | output | 18 | Memory address bus |
| mem_ce1_no | output | 1 | Chip enable 1, active low |
| mem_ce2_o | output | 1 | Chip enable 2, active high |
| mem_ce3_no | output | 1 | Chip enable 3, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_dq_o | output | 24 | Data driven toward the memory |
| mem_dq_i | input | 24 | Data returned from the memory |
| mem_dq_oe_o | output | 1 | Controller drives the data bus |

## Verification
The bench targets back-to-back writes and reads at the lowest and highest addresses, a read directly after a write to the same word, and requests held valid while the controller is busy. A design that dropped write enable too early would lose the stored word, and a later read would return the old value. A design that drove the bus in the cycles after output enable rose would show the data enable inside the turnaround window. A design that accepted a request while busy would write the junk word, which a later read would reveal. A wrong capture edge would return the undriven-bus pattern instead of stored data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_WR, ST_WHOLD, ST_RD, ST_TURN} state_e;

  function automatic int ps2cyc(input int ps, input int clk_ps);
    int c;
    c = (ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int N_PWE = 2,
  parameter int N_WH  = 1,
  parameter int N_RD  = 3,
  parameter int N_TA  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o,
  output logic             sel_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(N_PWE - 1);
  localparam logic [CNT_W-1:0] WH_LD = CNT_W'(N_WH - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(N_TA - 1);

  state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        load_o     = 1'b1;
        state_d    = req_we_i ? ST_WR : ST_RD;
        load_val_o = req_we_i ? WR_LD : RD_LD;
      end
      ST_WR: if (last_i) begin
        load_o     = 1'b1;
        load_val_o = WH_LD;
        state_d    = ST_WHOLD;
      end
      ST_WHOLD: if (last_i) state_d = ST_IDLE;
      ST_RD: if (last_i) begin
        load_o     = 1'b1;
        load_val_o = TA_LD;
        capture_o  = 1'b1;
        state_d    = ST_TURN;
      end
      ST_TURN: if (last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o && req_valid_i;

  // memory strobes are registered so they leave the chip glitch free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_o   <= 1'b0;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_o   <= (state_d != ST_IDLE);
      we_n_o  <= (state_d != ST_WR);
      oe_n_o  <= (state_d != ST_RD);
      dq_oe_o <= (state_d == ST_WR);
    end
  end
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      dq_o       <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= capture_i;
      if (accept_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      if (capture_i) rd_data_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 24,
  parameter int CLK_PS    = 4000,
  parameter int T_WC_PS   = 10000,
  parameter int T_PWE_PS  = 7000,
  parameter int T_SD_PS   = 5500,
  parameter int T_AW_PS   = 7000,
  parameter int T_RC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 5000,
  parameter int T_HZOE_PS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce1_no,
  output logic              mem_ce2_o,
  output logic              mem_ce3_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int N_PWE = imax(imax(ps2cyc(T_PWE_PS, CLK_PS), ps2cyc(T_SD_PS, CLK_PS)),
                              ps2cyc(T_AW_PS, CLK_PS));
  localparam int N_WH  = imax(1, ps2cyc(T_WC_PS, CLK_PS) - N_PWE);
  localparam int N_RD  = imax(imax(ps2cyc(T_RC_PS, CLK_PS), ps2cyc(T_AA_PS, CLK_PS)),
                              ps2cyc(T_DOE_PS, CLK_PS));
  localparam int N_TA  = ps2cyc(T_HZOE_PS, CLK_PS);
  localparam int N_MAX = imax(imax(N_PWE, N_WH), imax(N_RD, N_TA));
  localparam int CNT_W = imax(1, $clog2(N_MAX + 1));

  logic             load, last, accept, capture, sel;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .last_o(last)
  );

  sram_seq #(
    .CNT_W(CNT_W), .N_PWE(N_PWE), .N_WH(N_WH), .N_RD(N_RD), .N_TA(N_TA)
  ) i_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .last_i(last),
    .load_o(load), .load_val_o(load_val), .accept_o(accept), .capture_o(capture),
    .ready_o(req_ready_o), .sel_o(sel), .we_n_o(mem_we_no), .oe_n_o(mem_oe_no),
    .dq_oe_o(mem_dq_oe_o)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dq (
    .clk_i, .rst_ni, .accept_i(accept), .addr_i(req_addr_i), .wdata_i(req_wdata_i),
    .capture_i(capture), .dq_i(mem_dq_i), .addr_o(mem_addr_o), .dq_o(mem_dq_o),
    .rd_valid_o, .rd_data_o
  );

  // mixed-polarity select: active pattern is 0,1,0
  assign mem_ce1_no = ~sel;
  assign mem_ce2_o  = sel;
  assign mem_ce3_no = ~sel;

  logic chip_on;
  assign chip_on = !mem_ce1_no && mem_ce2_o && !mem_ce3_no;

  logic [CNT_W-1:0] wl_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wl_cnt_q <= '0;
    else if (!mem_we_no) wl_cnt_q <= wl_cnt_q + 1'b1;
    else                 wl_cnt_q <= '0;
  end

  // R2
  strobe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no || !mem_oe_no) |-> chip_on);
  // R3
  we_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (wl_cnt_q >= CNT_W'(N_PWE)));
  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |=> ($stable(mem_addr_o) && $stable(mem_dq_o)));
  // R5
  rdv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R6
  dq_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (mem_oe_no && !mem_we_no));
  // R6
  turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mem_oe_no) |-> !mem_dq_oe_o);
  // R7
  busy_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> chip_on);
endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
  localparam int AW = 18;
  localparam int DW = 24;
  localparam int CLK_PS = 4000;

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PWE = mx(mx(cyc(7000), cyc(5500)), cyc(7000));
  localparam int E_WR  = E_PWE + mx(1, cyc(10000) - E_PWE);
  localparam int E_RD  = mx(mx(cyc(10000), cyc(10000)), cyc(5000));
  localparam int E_TA  = cyc(5000);
  localparam logic [DW-1:0] FLOAT = 24'h5A5A5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ce1_n, ce2, ce3_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_o, dq_i;
  logic [AW-1:0] m_addr;

  always #2 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .mem_addr_o(m_addr),
    .mem_ce1_no(ce1_n), .mem_ce2_o(ce2), .mem_ce3_no(ce3_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_dq_o(dq_o), .mem_dq_i(dq_i), .mem_dq_oe_o(dq_oe)
  );

  // behavioural memory, 64 words keyed by the low address bits
  logic [DW-1:0] mdl [64];
  logic [DW-1:0] ref_mem [64];
  logic sel;
  assign sel  = !ce1_n && ce2 && !ce3_n;
  assign dq_i = (sel && we_n && !oe_n) ? mdl[m_addr[5:0]] : FLOAT;
  always @(posedge we_n) if (sel === 1'b1) mdl[m_addr[5:0]] <= dq_o;

  int n_vec = 0, n_bad = 0;
  logic [DW-1:0] last_rd = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_chk();
    chk({ce1_n, ce2, ce3_n} == 3'b101, "R2 idle deselect", {ce1_n, ce2, ce3_n}, 3'b101);
    chk(we_n && oe_n && !dq_oe, "R1 idle strobes", {we_n, oe_n, dq_oe}, 3'b110);
  endtask

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
    int busy = 0, wl = 0, ol = 0, rv = 0;
    logic [DW-1:0] got = '0;
    logic [DW-1:0] rd_before;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    rd_before = rd_data;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      req_we = 1'b1; req_addr = ~a; req_wdata = ~d;   // R7: must be ignored
    end else req_valid = 1'b0;
    while (!req_ready && busy < 40) begin
      busy++;
      chk(sel, "R2 selected in access", sel, 1);
      chk(m_addr == a, "R4 address held", m_addr, a);
      chk(dq_oe == (!we_n && oe_n), "R6 drive window", dq_oe, !we_n && oe_n);
      if (!we_n) begin
        wl++;
        chk(oe_n && dq_o == d, "R3 write data/oe", dq_o, d);
      end
      if (!oe_n) ol++;
      if (rd_valid) begin rv++; got = rd_data; end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (we) begin
      chk(wl == E_PWE, "R3 we low cycles", wl, E_PWE);
      chk(busy == E_WR, "R9 write busy cycles", busy, E_WR);
      chk(rd_data == rd_before, "R8 rd_data kept over write", rd_data, rd_before);
      chk(!rd_valid && rv == 0, "R8 no strobe on write", rv, 0);
      ref_mem[a[5:0]] = d;
    end else begin
      chk(wl == 0, "R7 no write during read", wl, 0);
      chk(ol == E_RD, "R5 oe low cycles", ol, E_RD);
      chk(rv == 1, "R5 one strobe", rv, 1);
      chk(got == ref_mem[a[5:0]], "R5 read data", got, ref_mem[a[5:0]]);
      chk(busy == E_RD + E_TA, "R6 read busy with turnaround", busy, E_RD + E_TA);
      last_rd = got;
    end
    idle_chk();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mdl[i] = '0; ref_mem[i] = '0; end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad + 0);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    idle_chk();
    chk(req_ready && !rd_valid, "R1 reset ready", {req_ready, rd_valid}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_chk();
    chk(req_ready && !rd_valid && rd_data == '0, "R1 after reset", rd_data, 0);
    // directed corners
    do_op(1'b1, 18'h00000, 24'hFFFFFF, 1'b0);
    do_op(1'b1, 18'h3FFFF, 24'h000001, 1'b0);
    do_op(1'b0, 18'h00000, '0, 1'b0);
    do_op(1'b0, 18'h3FFFF, '0, 1'b0);
    do_op(1'b1, 18'h00005, 24'hABCDEF, 1'b0);
    do_op(1'b0, 18'h00005, '0, 1'b0);
    do_op(1'b0, 18'h00005, '0, 1'b1);          // junk write to ~addr held valid
    do_op(1'b1, 18'h00011, 24'h123456, 1'b1);
    do_op(1'b0, ~18'h00005, '0, 1'b0);         // R7 junk target untouched
    do_op(1'b0, ~18'h00011, '0, 1'b0);
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      do_op($urandom_range(0, 1) == 1, a, DW'($urandom), 1'b0);
    end
    for (int i = 0; i < 64; i++) do_op(1'b0, AW'(i), '0, 1'b0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule